// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a small queue between a core's store retire port and the write port of a data cache. Retired stores are accepted in one cycle and then written to the cache in the background, oldest first, through a valid/ready handshake. The store side does not wait for the cache unless every entry is taken.

Each cycle a load may present an address and a size. The block compares that load against every pending store at once. The newest pending store that touches any of the load's bytes decides the outcome:

- If that store holds all of the load's bytes, the block supplies the data itself.
- If no pending store touches the load, the load is sent to the cache.
- If the newest overlapping store holds only some of the load's bytes, the block reports a forwarding stall and counts it.

A fence input stops new stores from entering. A done signal rises once the queue has fully drained.

All accesses are naturally aligned within an 8-byte word. Data is carried lane-aligned: byte lane i of a data bus belongs to address offset i within the word.

Top module: `sb_store_buffer`

## Requirements
- R1: After a synchronous active-high reset the queue is empty: `cw_valid` is 0, `st_ready` is 1, `fence_done` follows `fence_req`, and `stall_count` is 0.
- R2: A store is accepted on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is low exactly when DEPTH stores are pending or `fence_req` is high.
- R3: Pending stores appear on the cache write port strictly in acceptance order. `cw_valid` is high whenever at least one store is pending. While `cw_ready` is low, the presented store stays unchanged. `cw_data` carries the store data with the lanes outside its mask cleared to zero.
- R4: The size code selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. The lane mask is that many ones, shifted left by address bits [2:0]. `cw_addr` is the store address with bits [2:0] cleared, and `cw_mask` is that lane mask.
- R5: A valid load whose lanes do not overlap the lanes of any pending store in the same word raises `ld_miss` only.
- R6: When the newest pending store that overlaps a load covers every lane of the load, `ld_fwd` is raised. `ld_data` then holds that store's bytes in the load's lanes and zero elsewhere, even when older stores to the same lanes are pending.
- R7: When the newest overlapping pending store lacks some of the load's lanes, `ld_stall` is raised alone, and the load is neither forwarded nor sent to the cache.
- R8: A store accepted in a cycle is not seen by a load presented in that same cycle. It is seen from the next cycle on.
- R9: While `fence_req` is high, no store is accepted. `fence_done` is high exactly when `fence_req` is high and no store is pending.
- R10: `stall_count` rises by one on each clock edge where `ld_valid` and `ld_stall` are both high, and it saturates at its maximum value.
- R11: With `ld_valid` low, `ld_fwd`, `ld_miss`, `ld_stall` and `ld_data` are all zero. With `ld_valid` high, exactly one of the three flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Retired store offered |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | ADDR_W | Store byte address (aligned to its size) |
| st_size | input | 2 | Store size code (0:1B, 1:2B, 2:4B, 3:8B) |
| st_data | input | 64 | Store data, lane-aligned |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load byte address (aligned to its size) |
| ld_size | input | 2 | Load size code |
| ld_fwd | output | 1 | Load served from the buffer |
| ld_miss | output | 1 | Load must read the cache |
| ld_stall | output | 1 | Partial overlap, load must wait |
| ld_data | output | 64 | Forwarded data, lane-aligned |
| fence_req | input | 1 | Fence pending: hold off new stores |
| fence_done | output | 1 | Fence satisfied: queue empty |
| cw_valid | output | 1 | Cache write offered |
| cw_ready | input | 1 | Cache takes the write |
| cw_addr | output | ADDR_W | Word-aligned write address |
| cw_mask | output | 8 | Byte lanes to write |
| cw_data | output | 64 | Write data, lane-aligned |
| stall_count | output | CNT_W | Saturating count of stall cycles |

## Verification
The bench keeps a queue model of the pending stores and compares every output on every cycle. The stimulus targets the following corner cases:

- **Width aliasing.** A narrow store is followed by a wider load at the same address. A design that forwarded here would return stale upper bytes instead of stalling.
- **Layered stores to one word.** An older store covers the load but a newer one only partly does. A design that picked the oldest match, or any covering match, would forward wrong data.
- **Same-cycle store and load.** A design that searched the incoming store would forward a value it has not yet accepted.
- **Back-pressure.** The queue is filled with the cache stalled, and a fence is raised with entries pending. A counter off by one would overrun the queue or drop a store, which would show up as a wrong or missing write on the cache port.
- **Counter wrap.** With a narrow stall counter, a counter that wraps instead of saturating is caught.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int unsigned LANES  = 8;
    localparam int unsigned OFF_W  = $clog2(LANES);
    localparam int unsigned DATA_W = LANES * 8;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [DATA_W-1:0] word_data_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic fwd;
        logic miss;
        logic stall;
    } ld_verdict_t;

    // Lanes touched by an aligned access of the given size at the given offset.
    function automatic lane_mask_t lane_mask(logic [1:0] sz, logic [OFF_W-1:0] off);
        lane_mask_t m;
        int         n;
        n = 1 << sz;
        for (int i = 0; i < int'(LANES); i++) begin
            m[i] = (i >= int'(off)) && (i < int'(off) + n);
        end
        return m;
    endfunction

    // Expand a lane mask to a bit mask over the data word.
    function automatic word_data_t lane_bits(lane_mask_t m);
        word_data_t b;
        for (int i = 0; i < int'(LANES); i++) begin
            b[8*i +: 8] = {8{m[i]}};
        end
        return b;
    endfunction
endpackage

// File: rtl/sb_queue.sv
module sb_queue
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WA_W  = 29,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned QC_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WA_W-1:0]   in_word,
    input  lane_mask_t        in_mask,
    input  word_data_t        in_data,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [IDX_W-1:0]  head,
    output logic [QC_W-1:0]   count,
    output logic [WA_W-1:0]   word_q [DEPTH],
    output lane_mask_t        mask_q [DEPTH],
    output word_data_t        data_q [DEPTH]
);
    logic [IDX_W-1:0] tail;

    function automatic logic [IDX_W-1:0] nxt(logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == QC_W'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                word_q[tail] <= in_word;
                mask_q[tail] <= in_mask;
                data_q[tail] <= in_data;
                tail         <= nxt(tail);
            end
            if (pop) head <= nxt(head);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the number of entries
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= QC_W'(DEPTH));
    // R1: the cycle after reset the queue is empty
    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> (count == '0));
    // R3: a pop never happens on an empty queue
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);
endmodule

// File: rtl/sb_search.sv
module sb_search
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WA_W  = 29,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned QC_W  = $clog2(DEPTH + 1)
) (
    input  logic              ld_valid,
    input  logic [WA_W-1:0]   ld_word,
    input  lane_mask_t        ld_mask,
    input  logic [IDX_W-1:0]  head,
    input  logic [QC_W-1:0]   count,
    input  logic [WA_W-1:0]   word_q [DEPTH],
    input  lane_mask_t        mask_q [DEPTH],
    input  word_data_t        data_q [DEPTH],
    output ld_verdict_t       verdict,
    output word_data_t        fwd_data
);
    logic [DEPTH-1:0] touch;
    logic             found;
    logic [IDX_W-1:0] sel;
    logic             covers;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign touch[g] = (word_q[g] == ld_word) && (|(mask_q[g] & ld_mask));
    end

    // Walk from oldest to newest; the last overlapping entry wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < int'(DEPTH); k++) begin
            int j;
            j = (int'(head) + k) % int'(DEPTH);
            if (k < int'(count) && touch[j]) begin
                found = 1'b1;
                sel   = IDX_W'(j);
            end
        end
    end

    assign covers = ((mask_q[sel] & ld_mask) == ld_mask);

    always_comb begin
        verdict       = '0;
        fwd_data      = '0;
        if (ld_valid) begin
            verdict.miss  = !found;
            verdict.fwd   = found && covers;
            verdict.stall = found && !covers;
            if (found && covers) fwd_data = data_q[sel] & lane_bits(ld_mask);
        end
    end
endmodule

// File: rtl/sb_stall_ctr.sv
module sb_stall_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
    end

    // R10: each stall cycle below the ceiling adds exactly one
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt != '1) |=> (cnt == $past(cnt) + CNT_W'(1)));
    // R10: the count holds at its ceiling
    a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> (cnt == '1));
    // R10: without a stall the count does not move
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned WA_W  = ADDR_W - OFF_W,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned QC_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [63:0]       st_data,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    output logic              ld_fwd,
    output logic              ld_miss,
    output logic              ld_stall,
    output logic [63:0]       ld_data,
    input  logic              fence_req,
    output logic              fence_done,
    output logic              cw_valid,
    input  logic              cw_ready,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [7:0]        cw_mask,
    output logic [63:0]       cw_data,
    output logic [CNT_W-1:0]  stall_count
);
    logic              full, empty, push, pop;
    logic [IDX_W-1:0]  head;
    logic [QC_W-1:0]   count;
    logic [WA_W-1:0]   word_q [DEPTH];
    lane_mask_t        mask_q [DEPTH];
    word_data_t        data_q [DEPTH];
    lane_mask_t        st_mask;
    ld_verdict_t       verdict;

    assign st_mask  = lane_mask(st_size, st_addr[OFF_W-1:0]);
    assign st_ready = !full && !fence_req;
    assign push     = st_valid && st_ready;
    assign cw_valid = !empty;
    assign pop      = cw_valid && cw_ready;

    sb_queue #(.DEPTH(DEPTH), .WA_W(WA_W)) queue_i (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .in_word (st_addr[ADDR_W-1:OFF_W]),
        .in_mask (st_mask),
        .in_data (st_data & lane_bits(st_mask)),
        .pop     (pop),
        .full    (full),
        .empty   (empty),
        .head    (head),
        .count   (count),
        .word_q  (word_q),
        .mask_q  (mask_q),
        .data_q  (data_q)
    );

    sb_search #(.DEPTH(DEPTH), .WA_W(WA_W)) search_i (
        .ld_valid (ld_valid),
        .ld_word  (ld_addr[ADDR_W-1:OFF_W]),
        .ld_mask  (lane_mask(ld_size, ld_addr[OFF_W-1:0])),
        .head     (head),
        .count    (count),
        .word_q   (word_q),
        .mask_q   (mask_q),
        .data_q   (data_q),
        .verdict  (verdict),
        .fwd_data (ld_data)
    );

    sb_stall_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk (clk),
        .rst (rst),
        .inc (ld_valid && verdict.stall),
        .cnt (stall_count)
    );

    assign ld_fwd     = verdict.fwd;
    assign ld_miss    = verdict.miss;
    assign ld_stall   = verdict.stall;
    assign fence_done = fence_req && empty;
    assign cw_addr    = {word_q[head], {OFF_W{1'b0}}};
    assign cw_mask    = mask_q[head];
    assign cw_data    = data_q[head];

    // R3: a write held off by the cache stays on the port unchanged
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && !cw_ready) |=>
            (cw_valid && $stable(cw_addr) && $stable(cw_mask) && $stable(cw_data)));
    // R11: a valid load gets exactly one verdict
    a_r11_one_verdict: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> ($countones({ld_fwd, ld_miss, ld_stall}) == 1));
    // R11: no verdict and no data without a load
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (!ld_fwd && !ld_miss && !ld_stall && ld_data == '0));
    // R9: a fence admits no store, and the queue only shrinks under it
    a_r9_fence_blocks: assert property (@(posedge clk) disable iff (rst)
        fence_req |-> !st_ready);
    // R6: forwarded data never has bytes outside the load's lanes
    a_r6_fwd_lanes: assert property (@(posedge clk) disable iff (rst)
        ld_fwd |-> ((ld_data & ~lane_bits(lane_mask(ld_size, ld_addr[OFF_W-1:0]))) == '0));
endmodule

// File: tb/sb_store_buffer_tb.sv
`timescale 1ns/1ps
module sb_store_buffer_tb_top;
    localparam int DEPTH = 8;
    localparam int CMAX  = 15;

    logic        clk = 0, rst = 1;
    logic        st_valid = 0, ld_valid = 0, fence_req = 0, cw_ready = 0;
    logic [31:0] st_addr = 0, ld_addr = 0;
    logic [1:0]  st_size = 0, ld_size = 0;
    logic [63:0] st_data = 0;
    logic        st_ready, ld_fwd, ld_miss, ld_stall, fence_done, cw_valid;
    logic [63:0] ld_data, cw_data;
    logic [31:0] cw_addr;
    logic [7:0]  cw_mask;
    logic [3:0]  stall_count;

    int n_chk = 0, n_bad = 0, cyc = 0, ref_cnt = 0;
    logic [28:0] mw[$];
    logic [7:0]  mm[$];
    logic [63:0] md[$];

    always #5 clk = ~clk;

    sb_store_buffer #(.ADDR_W(32), .DEPTH(DEPTH), .CNT_W(4)) dut_i (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_fwd(ld_fwd), .ld_miss(ld_miss), .ld_stall(ld_stall), .ld_data(ld_data),
        .fence_req(fence_req), .fence_done(fence_done), .cw_valid(cw_valid),
        .cw_ready(cw_ready), .cw_addr(cw_addr), .cw_mask(cw_mask),
        .cw_data(cw_data), .stall_count(stall_count));

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    function automatic logic [7:0] bytes_of(logic [1:0] sz, logic [2:0] off);
        logic [7:0] m = '0;
        for (int i = 0; i < (1 << sz); i++) m[int'(off) + i] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] bits_of(logic [7:0] m);
        logic [63:0] b = '0;
        for (int i = 0; i < 8; i++) if (m[i]) b[8*i +: 8] = 8'hFF;
        return b;
    endfunction

    // Compare every output against the model, then advance one clock.
    task automatic tick();
        bit         rdy, cwv, found, do_push, do_pop;
        int         sel;
        logic [7:0] lm, sm;
        logic [2:0] ev;
        logic [63:0] ed;
        string      tag;
        #1;
        rdy = (mw.size() < DEPTH) && !fence_req;
        cwv = (mw.size() > 0);
        chk(st_ready === rdy, fence_req ? "R9" : "R2", "st_ready", 64'(st_ready), 64'(rdy));
        chk(cw_valid === cwv, "R3", "cw_valid", 64'(cw_valid), 64'(cwv));
        if (cwv) begin
            chk(cw_addr === {mw[0], 3'b000}, "R4", "cw_addr", 64'(cw_addr), 64'({mw[0], 3'b000}));
            chk(cw_mask === mm[0], "R4", "cw_mask", 64'(cw_mask), 64'(mm[0]));
            chk(cw_data === md[0], "R3", "cw_data", cw_data, md[0]);
        end
        chk(fence_done === (fence_req && !cwv), "R9", "fence_done",
            64'(fence_done), 64'(fence_req && !cwv));
        chk(stall_count === 4'(ref_cnt), "R10", "stall_count", 64'(stall_count), 64'(ref_cnt));
        lm = bytes_of(ld_size, ld_addr[2:0]);
        found = 0; sel = 0;
        for (int i = 0; i < mw.size(); i++)
            if (mw[i] == ld_addr[31:3] && (mm[i] & lm) != 0) begin found = 1; sel = i; end
        ev = 3'b000; ed = '0; tag = "R11";
        if (ld_valid) begin
            if (!found) begin ev = 3'b010; tag = "R5"; end
            else if ((mm[sel] & lm) == lm) begin ev = 3'b100; ed = md[sel] & bits_of(lm); tag = "R6"; end
            else begin ev = 3'b001; tag = "R7"; end
        end
        chk({ld_fwd, ld_miss, ld_stall} === ev, tag, "fwd/miss/stall",
            64'({ld_fwd, ld_miss, ld_stall}), 64'(ev));
        chk(ld_data === ed, ev[2] ? "R6" : "R11", "ld_data", ld_data, ed);
        do_push = st_valid && rdy;
        do_pop  = cwv && cw_ready;
        sm = bytes_of(st_size, st_addr[2:0]);
        @(posedge clk);
        cyc++;
        if (do_pop) begin void'(mw.pop_front()); void'(mm.pop_front()); void'(md.pop_front()); end
        if (do_push) begin
            mw.push_back(st_addr[31:3]); mm.push_back(sm); md.push_back(st_data & bits_of(sm));
        end
        if (ld_valid && ev == 3'b001 && ref_cnt < CMAX) ref_cnt++;
        @(negedge clk);
    endtask

    task automatic set_st(bit v, logic [31:0] a, logic [1:0] s, logic [63:0] d);
        st_valid = v; st_addr = a; st_size = s; st_data = d;
    endtask
    task automatic set_ld(bit v, logic [31:0] a, logic [1:0] s);
        ld_valid = v; ld_addr = a; ld_size = s;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired before the run ended (all requirements)");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(cw_valid === 0, "R1", "cw_valid after reset", 64'(cw_valid), 0);
        chk(st_ready === 1, "R1", "st_ready after reset", 64'(st_ready), 1);
        chk(stall_count === 0, "R1", "stall_count after reset", 64'(stall_count), 0);
        chk(fence_done === 0, "R1", "fence_done after reset", 64'(fence_done), 0);

        // R8: same-cycle store and load to one address: load misses, then forwards
        set_st(1, 32'h300, 2'd3, 64'h1122334455667788); set_ld(1, 32'h300, 2'd3);
        #1; chk(ld_miss === 1, "R8", "same-cycle load not forwarded", 64'(ld_miss), 1);
        tick();
        set_st(0, 0, 0, 0);
        #1; chk(ld_fwd === 1 && ld_data === 64'h1122334455667788, "R8", "next-cycle forward",
                ld_data, 64'h1122334455667788);
        tick();

        // R7: 4-byte store, then 8-byte load at the same address stalls
        set_st(1, 32'h100, 2'd2, 64'hAAAA_BBBB_CCCC_DDDD); set_ld(0, 0, 0);
        tick(); set_st(0, 0, 0, 0);
        set_ld(1, 32'h100, 2'd3);
        #1; chk(ld_stall === 1, "R7", "wide load over narrow store", 64'(ld_stall), 1);
        tick();
        // R6: narrow load inside the store forwards
        set_ld(1, 32'h102, 2'd1);
        #1; chk(ld_fwd === 1 && ld_data === 64'h0000_0000_CCCC_0000, "R6", "inner half",
                ld_data, 64'h0000_0000_CCCC_0000);
        tick();
        // R5: other word misses
        set_ld(1, 32'h208, 2'd2);
        #1; chk(ld_miss === 1, "R5", "unrelated load", 64'(ld_miss), 1);
        tick();
        // R6: newer covering store wins over older one
        set_st(1, 32'h100, 2'd0, 64'h0000_0000_0000_0077); set_ld(0, 0, 0);
        tick(); set_st(0, 0, 0, 0);
        set_ld(1, 32'h100, 2'd0);
        #1; chk(ld_data === 64'h77, "R6", "youngest store", ld_data, 64'h77);
        tick();
        // R7: newest overlapper partial though older one covers
        set_ld(1, 32'h100, 2'd1);
        #1; chk(ld_stall === 1, "R7", "newest partial", 64'(ld_stall), 1);
        tick();
        set_ld(0, 0, 0);

        // R2: fill with the cache stalled
        for (int i = 0; i < DEPTH + 2; i++) begin
            set_st(1, 32'h400 + 32'(8 * i), 2'd3, 64'(i) * 64'h0101);
            tick();
        end
        #1; chk(st_ready === 0, "R2", "full queue", 64'(st_ready), 0);
        set_st(0, 0, 0, 0);
        // R9: fence drains
        fence_req = 1; cw_ready = 1;
        for (int i = 0; i < DEPTH + 2; i++) tick();
        #1; chk(fence_done === 1, "R9", "fence drained", 64'(fence_done), 1);
        fence_req = 0; tick();

        // random mix over a few words
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] s1, s2;
            logic [31:0] w1, w2;
            s1 = 2'($urandom % 4); s2 = 2'($urandom % 4);
            w1 = 32'h100 + 32'(8 * ($urandom % 3)); w2 = 32'h100 + 32'(8 * ($urandom % 3));
            set_st(($urandom % 2) == 0, w1 + 32'(($urandom % (8 >> s1)) << s1), s1,
                   {$urandom, $urandom});
            set_ld(($urandom % 3) != 0, w2 + 32'(($urandom % (8 >> s2)) << s2), s2);
            cw_ready  = ($urandom % 5) < 2;
            fence_req = ($urandom % 20) == 0;
            tick();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule